// File: doc/BRIEF.md
# Operand Tree Reduce and Accumulate

This block runs the data phase of one instruction over a branching path that is already in place. Each path termination offers one operand word, and a mask marks which terminations belong to the operand set. For an add-type operation the selected words are merged pairwise through a balanced tree, using either bitwise OR or bitwise AND at every branch point. The merged word is then added into the word of the arithmetic cell, and the block returns the sum as the new accumulator value. For a store, the arithmetic cell's word is sent to every termination in the operand set, with one write enable for each termination.

A request is a single transfer on a valid/ready channel. The request carries the operation, the termination mask, all termination words, the arithmetic cell's current word, and a flag that says whether an arithmetic cell was found on the predecessor line. The result appears on a second valid/ready channel exactly one clock after the request is accepted. While a result waits with `res_ready` low, every result output holds its value and `req_ready` stays low. A result slot freed in a cycle can accept a new request in that same cycle. If no arithmetic cell was found, a non-idle request produces an error result and writes nothing.

Top module: `optree_accum`

## Requirements
- R1: After reset, `res_valid`, `acc_we`, `err_no_arith` and every bit of `wb_en` are 0.
- R2: Operation code 1 (OR then add), with an arithmetic cell present, yields `acc_we`=1, `wb_en`=0 and `acc_data` = `acc_in` + (bitwise OR of all masked-in words).
- R3: Operation code 2 (AND then add), with an arithmetic cell present, yields `acc_we`=1, `wb_en`=0 and `acc_data` = `acc_in` + (bitwise AND of all masked-in words).
- R4: With an empty mask, the OR merge is all zeros, so `acc_data` = `acc_in`. The AND merge is all ones, so `acc_data` = `acc_in` - 1 modulo 2^W.
- R5: The addition is modulo 2^W, and any carry out of bit W-1 is dropped.
- R6: Operation code 3 (store), with an arithmetic cell present, yields `wb_en` equal to the request mask, `wb_data` = `acc_in` and `acc_we`=0.
- R7: The word of termination k (bits k*W+W-1 down to k*W of `req_words`) has no effect on `acc_data` when mask bit k is 0.
- R8: For operation codes 1, 2 and 3 with `arith_found`=0, the result has `err_no_arith`=1, `acc_we`=0 and `wb_en`=0.
- R9: Operation code 0 (idle) yields a result with `acc_we`=0, `wb_en`=0 and `err_no_arith`=0.
- R10: A request is accepted when `req_valid` and `req_ready` are both high, with `req_ready` = !`res_valid` || `res_ready`. Its result is valid on the next clock. While `res_valid` is high and `res_ready` is low, all result outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_op | input | 2 | 0 idle, 1 OR-add, 2 AND-add, 3 store |
| req_mask | input | N | Terminations in the operand set |
| req_words | input | N*W | Termination words, termination k at bits k*W+W-1:k*W |
| acc_in | input | W | Current word of the arithmetic cell |
| arith_found | input | 1 | An arithmetic cell exists on the predecessor line |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Result consumer can take it |
| acc_we | output | 1 | Write `acc_data` into the arithmetic cell |
| acc_data | output | W | Updated accumulator word |
| wb_en | output | N | Per-termination write enables |
| wb_data | output | W | Word written to enabled terminations |
| err_no_arith | output | 1 | Request needed an arithmetic cell and none was found |

## Verification
The bench builds the block with five terminations and an 8-bit word. Five is not a power of two, so three leaves of the padded tree must hold the identity fill of the selected merge. The narrow word makes carry wrap-around and the all-ones AND result of an empty mask easy to reach with both random and hand-picked values. A back-pressure sequence holds a result while a second request is already waiting, then checks the hold and the handover on the same edge.

// File: rtl/otr_pkg.sv
package otr_pkg;
  typedef enum logic [1:0] {
    OTR_IDLE    = 2'd0,
    OTR_OR_ADD  = 2'd1,
    OTR_AND_ADD = 2'd2,
    OTR_STORE   = 2'd3
  } otr_op_e;
endpackage

// File: rtl/otr_merge_tree.sv
// Balanced merge tree. Leaves are padded up to a power of two. A leaf that is
// masked out or padded holds the identity of the chosen merge: zeros for OR,
// ones for AND.
module otr_merge_tree #(
  parameter int N = 8,
  parameter int W = 16
) (
  input  logic [N-1:0]   mask,
  input  logic [N*W-1:0] words,
  input  logic           use_and,
  output logic [W-1:0]   merged
);
  localparam int LVL = (N > 1) ? $clog2(N) : 0;
  localparam int P   = 1 << LVL;

  logic [W-1:0] fill;
  assign fill = {W{use_and}};

  genvar lv, k;
  generate
    for (lv = 0; lv <= LVL; lv++) begin : g_lvl
      localparam int CNT = P >> lv;
      logic [W-1:0] v [CNT];
      if (lv == 0) begin : g_leaf
        for (k = 0; k < CNT; k++) begin : g_l
          if (k < N) begin : g_real
            assign v[k] = mask[k] ? words[k*W +: W] : fill;
          end else begin : g_pad
            assign v[k] = fill;
          end
        end
      end else begin : g_node
        for (k = 0; k < CNT; k++) begin : g_n
          assign v[k] = use_and ? (g_lvl[lv-1].v[2*k] & g_lvl[lv-1].v[2*k+1])
                                : (g_lvl[lv-1].v[2*k] | g_lvl[lv-1].v[2*k+1]);
        end
      end
    end
  endgenerate

  assign merged = g_lvl[LVL].v[0];
endmodule

// File: rtl/otr_accum_add.sv
// Modulo 2^W adder; the carry out is simply not kept.
module otr_accum_add #(
  parameter int W = 16
) (
  input  logic [W-1:0] acc,
  input  logic [W-1:0] operand,
  output logic [W-1:0] sum
);
  assign sum = acc + operand;
endmodule

// File: rtl/otr_out_stage.sv
// Single result register with valid/ready hold behaviour.
module otr_out_stage #(
  parameter int N = 8,
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         n_acc_we,
  input  logic [W-1:0] n_acc_data,
  input  logic [N-1:0] n_wb_en,
  input  logic [W-1:0] n_wb_data,
  input  logic         n_err,
  input  logic         res_ready,
  output logic         res_valid,
  output logic         acc_we,
  output logic [W-1:0] acc_data,
  output logic [N-1:0] wb_en,
  output logic [W-1:0] wb_data,
  output logic         err
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      acc_we    <= 1'b0;
      acc_data  <= '0;
      wb_en     <= '0;
      wb_data   <= '0;
      err       <= 1'b0;
    end else if (load) begin
      res_valid <= 1'b1;
      acc_we    <= n_acc_we;
      acc_data  <= n_acc_data;
      wb_en     <= n_wb_en;
      wb_data   <= n_wb_data;
      err       <= n_err;
    end else if (res_ready) begin
      res_valid <= 1'b0;
      acc_we    <= 1'b0;
      wb_en     <= '0;
      err       <= 1'b0;
    end
  end
endmodule

// File: rtl/optree_accum.sv
module optree_accum #(
  parameter int N = 8,
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [1:0]     req_op,
  input  logic [N-1:0]   req_mask,
  input  logic [N*W-1:0] req_words,
  input  logic [W-1:0]   acc_in,
  input  logic           arith_found,
  output logic           res_valid,
  input  logic           res_ready,
  output logic           acc_we,
  output logic [W-1:0]   acc_data,
  output logic [N-1:0]   wb_en,
  output logic [W-1:0]   wb_data,
  output logic           err_no_arith
);
  import otr_pkg::*;

  otr_op_e      op;
  logic         is_add;
  logic         is_store;
  logic         missing;
  logic         accept;
  logic [W-1:0] merged;
  logic [W-1:0] sum;
  logic         n_acc_we;
  logic [N-1:0] n_wb_en;
  logic [W-1:0] n_wb_data;

  assign op       = otr_op_e'(req_op);
  assign is_add   = (op == OTR_OR_ADD) || (op == OTR_AND_ADD);
  assign is_store = (op == OTR_STORE);
  assign missing  = (op != OTR_IDLE) && !arith_found;

  assign req_ready = !res_valid || res_ready;
  assign accept    = req_valid && req_ready;

  otr_merge_tree #(.N(N), .W(W)) tree_i (
    .mask    (req_mask),
    .words   (req_words),
    .use_and (op == OTR_AND_ADD),
    .merged  (merged)
  );

  otr_accum_add #(.W(W)) add_i (
    .acc     (acc_in),
    .operand (merged),
    .sum     (sum)
  );

  assign n_acc_we  = is_add && arith_found;
  assign n_wb_en   = (is_store && arith_found) ? req_mask : '0;
  assign n_wb_data = acc_in;

  otr_out_stage #(.N(N), .W(W)) out_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .n_acc_we   (n_acc_we),
    .n_acc_data (sum),
    .n_wb_en    (n_wb_en),
    .n_wb_data  (n_wb_data),
    .n_err      (missing),
    .res_ready  (res_ready),
    .res_valid  (res_valid),
    .acc_we     (acc_we),
    .acc_data   (acc_data),
    .wb_en      (wb_en),
    .wb_data    (wb_data),
    .err        (err_no_arith)
  );
endmodule

// File: rtl/otr_checker.sv
module otr_checker #(
  parameter int N = 8,
  parameter int W = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic           req_ready,
  input logic [1:0]     req_op,
  input logic [N-1:0]   req_mask,
  input logic [W-1:0]   acc_in,
  input logic           arith_found,
  input logic           res_valid,
  input logic           res_ready,
  input logic           acc_we,
  input logic [W-1:0]   acc_data,
  input logic [N-1:0]   wb_en,
  input logic [W-1:0]   wb_data,
  input logic           err_no_arith
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (!acc_we && wb_en == '0 && !err_no_arith));

  a_r8_err_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    err_no_arith |-> (!acc_we && wb_en == '0));

  a_r6_store_targets: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == 2'd3 && arith_found)
      |=> (wb_en == $past(req_mask) && wb_data == $past(acc_in) && !acc_we));

  a_r10_result_next: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> res_valid);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(acc_we) && $stable(acc_data)
      && $stable(wb_en) && $stable(wb_data) && $stable(err_no_arith)));
endmodule

bind optree_accum otr_checker #(.N(N), .W(W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_op       (req_op),
  .req_mask     (req_mask),
  .acc_in       (acc_in),
  .arith_found  (arith_found),
  .res_valid    (res_valid),
  .res_ready    (res_ready),
  .acc_we       (acc_we),
  .acc_data     (acc_data),
  .wb_en        (wb_en),
  .wb_data      (wb_data),
  .err_no_arith (err_no_arith)
);

// File: tb/optree_accum_tb_top.sv
`timescale 1ns/1ps
module optree_accum_tb_top;
  localparam int N = 5;
  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           req_valid = 1'b0;
  logic           req_ready;
  logic [1:0]     req_op = 2'd0;
  logic [N-1:0]   req_mask = '0;
  logic [N*W-1:0] req_words = '0;
  logic [W-1:0]   acc_in = '0;
  logic           arith_found = 1'b0;
  logic           res_valid;
  logic           res_ready = 1'b1;
  logic           acc_we;
  logic [W-1:0]   acc_data;
  logic [N-1:0]   wb_en;
  logic [W-1:0]   wb_data;
  logic           err_no_arith;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  optree_accum #(.N(N), .W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_mask(req_mask), .req_words(req_words), .acc_in(acc_in),
    .arith_found(arith_found), .res_valid(res_valid), .res_ready(res_ready),
    .acc_we(acc_we), .acc_data(acc_data), .wb_en(wb_en), .wb_data(wb_data),
    .err_no_arith(err_no_arith)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] ref_merge(input bit use_and, input logic [N-1:0] m,
                                             input logic [N*W-1:0] ws);
    logic [W-1:0] r = use_and ? '1 : '0;
    for (int k = 0; k < N; k++)
      if (m[k]) r = use_and ? (r & ws[k*W +: W]) : (r | ws[k*W +: W]);
    return r;
  endfunction

  // Drive one request at a falling edge, let it be taken, check the result
  task automatic run_op(input logic [1:0] op, input logic [N-1:0] m,
                        input logic [N*W-1:0] ws, input logic [W-1:0] a,
                        input bit found, input string tag);
    logic [W-1:0] exp_acc;
    bit exp_we, exp_err;
    logic [N-1:0] exp_wb;
    @(negedge clk);
    req_op = op; req_mask = m; req_words = ws; acc_in = a; arith_found = found;
    req_valid = 1'b1; res_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    exp_err = (op != 2'd0) && !found;
    exp_we  = (op == 2'd1 || op == 2'd2) && found;
    exp_wb  = (op == 2'd3 && found) ? m : '0;
    exp_acc = a + ref_merge(op == 2'd2, m, ws);
    chk(res_valid == 1'b1, {tag, " R10 valid"}, int'(res_valid), 1);
    chk(acc_we == exp_we, {tag, " acc_we"}, int'(acc_we), int'(exp_we));
    chk(wb_en == exp_wb, {tag, " wb_en"}, int'(wb_en), int'(exp_wb));
    chk(err_no_arith == exp_err, {tag, " err"}, int'(err_no_arith), int'(exp_err));
    if (exp_we) chk(acc_data == exp_acc, {tag, " acc_data"}, int'(acc_data), int'(exp_acc));
    if (exp_wb != '0) chk(wb_data == a, {tag, " wb_data"}, int'(wb_data), int'(a));
  endtask

  initial begin
    #200000;
    bad++;
    $display("FAIL R10 watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [N*W-1:0] ws;
    logic [W-1:0] held;
    void'($urandom(32'd20250611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(res_valid == 0 && acc_we == 0 && wb_en == '0 && err_no_arith == 0,
        "R1 reset outputs", int'({res_valid, acc_we, err_no_arith}), 0);
    rst_n = 1'b1;

    // Directed corner cases
    ws = {8'h80, 8'h01, 8'h10, 8'h02, 8'h04};
    run_op(2'd1, 5'b10101, ws, 8'h11, 1'b1, "R2 or-add");
    run_op(2'd2, 5'b11111, {5{8'hF3}}, 8'h01, 1'b1, "R3 and-add");
    run_op(2'd1, 5'b00000, ws, 8'h37, 1'b1, "R4 empty or");
    run_op(2'd2, 5'b00000, ws, 8'h05, 1'b1, "R4 empty and");
    run_op(2'd1, 5'b00001, {8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h20}, 8'hF0, 1'b1, "R5 wrap");
    run_op(2'd1, 5'b00001, {8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h00}, 8'h42, 1'b1, "R7 masked out");
    run_op(2'd2, 5'b10000, {8'h0F, 8'h00, 8'h00, 8'h00, 8'h00}, 8'h01, 1'b1, "R7 and masked");
    run_op(2'd3, 5'b01011, ws, 8'hA5, 1'b1, "R6 store");
    run_op(2'd1, 5'b11111, ws, 8'h10, 1'b0, "R8 none or");
    run_op(2'd3, 5'b11111, ws, 8'h10, 1'b0, "R8 none store");
    run_op(2'd0, 5'b11111, ws, 8'h10, 1'b1, "R9 idle");

    // R10 back-pressure: hold the result and refuse a second request
    @(negedge clk);
    req_op = 2'd1; req_mask = 5'b00011; req_words = {24'h0, 8'h03, 8'h04};
    acc_in = 8'h10; arith_found = 1'b1; req_valid = 1'b1; res_ready = 1'b0;
    @(negedge clk);
    chk(res_valid && acc_data == 8'h17, "R10 first result", int'(acc_data), 'h17);
    held = acc_data;
    req_op = 2'd3; req_mask = 5'b10000; acc_in = 8'h66;
    chk(req_ready == 1'b0, "R10 ready low while held", int'(req_ready), 0);
    @(negedge clk);
    chk(res_valid && acc_data == held && acc_we && wb_en == '0,
        "R10 hold", int'(acc_data), int'(held));
    res_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(res_valid && wb_en == 5'b10000 && wb_data == 8'h66 && !acc_we,
        "R10 handover R6", int'(wb_en), 'h10);
    @(negedge clk);
    chk(res_valid == 1'b0, "R10 drained", int'(res_valid), 0);

    // Constrained random mix
    for (int i = 0; i < 300; i++) begin
      logic [1:0] op;
      logic [N-1:0] m;
      logic [N*W-1:0] w;
      op = 2'($urandom);
      m  = N'($urandom);
      w  = {$urandom, $urandom};
      run_op(op, m, w, W'($urandom), ($urandom % 8) != 0, "R2 R3 R6 R8 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule